// File: doc/BRIEF.md
# Inter-Processor Interrupt Unit

This block lets the cores of a small cluster interrupt one another. Every core has its own command lane into the block. On that lane it can raise an interrupt toward another core, or toward itself. It can also poll whether an interrupt it raised earlier is still outstanding, ask which cores are currently interrupting it, and retire the interrupt of one chosen sender. The block holds one pending flag for every ordered pair of sender and target. It drives a single interrupt line per core, and that line stays high while any flag addressed to the core is set.

Several senders may target one core at nearly the same time. Their requests then merge onto that core's single line. The receiving core learns who interrupted it from the sender mask returned by a source query, and then retires each sender separately. A sender is expected to poll the status of its earlier request before raising a new one to the same target. The block itself makes a repeated raise harmless.

Top module: `ipi_unit`

## Requirements
- R1: After reset every pending flag is clear, `irq_o` is all zero and `rb_valid_o` is all zero.
- R2: A raise command (code 0x01, parameter = target index) from core s sets the flag of pair (s, target). `irq_o[target]` is high from the cycle after the command.
- R3: A status command (code 0x02, parameter = target index) from core s makes `rb_valid_o[s]` high in the next cycle. Its lane then reads 1 if pair (s, target) is pending and 0 if not, with all other bits zero. The value reflects the flags as they were before any update made in the same cycle.
- R4: A source query (code 0x03, parameter ignored) from core t makes `rb_valid_o[t]` high in the next cycle. Its lane then carries a mask in which bit s is set exactly when pair (s, t) is pending.
- R5: Raises from several senders to one target collapse onto the single `irq_o` bit of that target, and the source query then shows several bits set.
- R6: An acknowledge command (code 0x04, parameter = sender index) from core t clears only the flag of pair (sender, t). Every other pair keeps its value.
- R7: `irq_o[t]` stays high while any flag toward t is set. It falls in the cycle after the last such flag is cleared.
- R8: When a raise of pair (s, t) and an acknowledge of the same pair arrive in the same cycle, the flag ends set.
- R9: A command with any other code, or a raise, status or acknowledge whose parameter is not below `N_CORES`, changes no flag and produces no readback.
- R10: All cores may issue commands in the same cycle. Each core's result appears only on its own lane `rb_data_o[c*RB_W +: RB_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | N_CORES | One command strobe per core |
| cmd_code_i | input | N_CORES*CMD_W | Command code per core |
| cmd_param_i | input | N_CORES*PARAM_W | Core-index parameter per core |
| rb_valid_o | output | N_CORES | Readback valid per core, one cycle after a read command |
| rb_data_o | output | N_CORES*RB_W | Readback word per core |
| irq_o | output | N_CORES | Interrupt line per core |

## Verification
The raise from one core and the acknowledge from its target can both hit the same pending flag in a single cycle. The bench provokes this by driving the sender's raise and the target's acknowledge of that sender on the same edge. It does so once with the flag clear and once with it already set. The outcome is judged at the target's interrupt line, which must stay high after that edge. It must fall only after a later acknowledge arrives alone. Status and source reads issued in the same cycle as updates are checked to return the flags as they stood before those updates.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam logic [7:0] OP_RAISE  = 8'h01;
  localparam logic [7:0] OP_STATUS = 8'h02;
  localparam logic [7:0] OP_SOURCE = 8'h03;
  localparam logic [7:0] OP_ACK    = 8'h04;

  typedef enum logic [1:0] {
    RB_NONE   = 2'd0,
    RB_STATUS = 2'd1,
    RB_SOURCE = 2'd2
  } rb_kind_e;
endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
  import ipi_pkg::*;
#(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned CMD_W   = 8,
  parameter int unsigned PARAM_W = 8,
  localparam int unsigned IDX_W  = (N_CORES < 2) ? 1 : $clog2(N_CORES)
) (
  input  logic               valid_i,
  input  logic [CMD_W-1:0]   code_i,
  input  logic [PARAM_W-1:0] param_i,
  output logic [N_CORES-1:0] raise_o,  // one-hot target
  output logic [N_CORES-1:0] ack_o,    // one-hot sender
  output rb_kind_e           rb_kind_o,
  output logic [IDX_W-1:0]   sel_o
);
  logic in_range;
  logic [N_CORES-1:0] onehot;

  assign in_range = param_i < PARAM_W'(N_CORES);
  assign sel_o    = param_i[IDX_W-1:0];

  always_comb begin
    onehot = '0;
    for (int i = 0; i < N_CORES; i++) begin
      if (param_i == PARAM_W'(i)) onehot[i] = 1'b1;
    end
  end

  always_comb begin
    raise_o   = '0;
    ack_o     = '0;
    rb_kind_o = RB_NONE;
    if (valid_i) begin
      if (code_i == CMD_W'(OP_RAISE) && in_range) begin
        raise_o = onehot;
      end else if (code_i == CMD_W'(OP_ACK) && in_range) begin
        ack_o = onehot;
      end else if (code_i == CMD_W'(OP_STATUS) && in_range) begin
        rb_kind_o = RB_STATUS;
      end else if (code_i == CMD_W'(OP_SOURCE)) begin
        rb_kind_o = RB_SOURCE;
      end
    end
  end
endmodule

// File: rtl/ipi_pend_matrix.sv
module ipi_pend_matrix #(
  parameter int unsigned N_CORES = 4,
  localparam int unsigned PAIRS  = N_CORES * N_CORES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PAIRS-1:0]   set_i,   // index sender*N_CORES + target
  input  logic [PAIRS-1:0]   clr_i,
  output logic [PAIRS-1:0]   pend_o,
  output logic [N_CORES-1:0] irq_o
);
  logic [PAIRS-1:0] pend_q;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pend_q[p] <= 1'b0;
      else if (set_i[p]) pend_q[p] <= 1'b1;  // raise wins over clear
      else if (clr_i[p]) pend_q[p] <= 1'b0;
    end
  end

  always_comb begin
    irq_o = '0;
    for (int s = 0; s < N_CORES; s++) begin
      for (int t = 0; t < N_CORES; t++) begin
        irq_o[t] = irq_o[t] | pend_q[s*N_CORES+t];
      end
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/ipi_readback.sv
module ipi_readback
  import ipi_pkg::*;
#(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned RB_W    = 8,
  localparam int unsigned IDX_W  = (N_CORES < 2) ? 1 : $clog2(N_CORES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  rb_kind_e           kind_i,
  input  logic [IDX_W-1:0]   sel_i,
  input  logic [N_CORES-1:0] row_i,  // pairs sent by this core
  input  logic [N_CORES-1:0] col_i,  // pairs aimed at this core
  output logic               valid_o,
  output logic [RB_W-1:0]    data_o
);
  logic [RB_W-1:0] data_d;

  always_comb begin
    data_d = '0;
    unique case (kind_i)
      RB_STATUS: data_d[0] = row_i[sel_i];
      RB_SOURCE: data_d[N_CORES-1:0] = col_i;
      default:   data_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= kind_i != RB_NONE;
      if (kind_i != RB_NONE) data_o <= data_d;
    end
  end
endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
  import ipi_pkg::*;
#(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned CMD_W   = 8,
  parameter int unsigned PARAM_W = 8,
  parameter int unsigned RB_W    = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_CORES-1:0]         cmd_valid_i,
  input  logic [N_CORES*CMD_W-1:0]   cmd_code_i,
  input  logic [N_CORES*PARAM_W-1:0] cmd_param_i,
  output logic [N_CORES-1:0]         rb_valid_o,
  output logic [N_CORES*RB_W-1:0]    rb_data_o,
  output logic [N_CORES-1:0]         irq_o
);
  localparam int unsigned PAIRS = N_CORES * N_CORES;
  localparam int unsigned IDX_W = (N_CORES < 2) ? 1 : $clog2(N_CORES);

  logic [N_CORES-1:0] raise_a [N_CORES];
  logic [N_CORES-1:0] ack_a   [N_CORES];
  rb_kind_e           kind_a  [N_CORES];
  logic [IDX_W-1:0]   sel_a   [N_CORES];
  logic [N_CORES-1:0] row_a   [N_CORES];
  logic [N_CORES-1:0] col_a   [N_CORES];
  logic [PAIRS-1:0]   set_flat, clr_flat, pend_flat;

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    ipi_cmd_decode #(
      .N_CORES(N_CORES), .CMD_W(CMD_W), .PARAM_W(PARAM_W)
    ) dec_i (
      .valid_i  (cmd_valid_i[c]),
      .code_i   (cmd_code_i[c*CMD_W +: CMD_W]),
      .param_i  (cmd_param_i[c*PARAM_W +: PARAM_W]),
      .raise_o  (raise_a[c]),
      .ack_o    (ack_a[c]),
      .rb_kind_o(kind_a[c]),
      .sel_o    (sel_a[c])
    );

    for (genvar o = 0; o < N_CORES; o++) begin : g_wire
      assign set_flat[c*N_CORES+o] = raise_a[c][o];   // c sends to o
      assign clr_flat[o*N_CORES+c] = ack_a[c][o];     // c retires sender o
      assign row_a[c][o]           = pend_flat[c*N_CORES+o];
      assign col_a[c][o]           = pend_flat[o*N_CORES+c];
    end

    ipi_readback #(
      .N_CORES(N_CORES), .RB_W(RB_W)
    ) rb_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .kind_i (kind_a[c]),
      .sel_i  (sel_a[c]),
      .row_i  (row_a[c]),
      .col_i  (col_a[c]),
      .valid_o(rb_valid_o[c]),
      .data_o (rb_data_o[c*RB_W +: RB_W])
    );
  end

  ipi_pend_matrix #(
    .N_CORES(N_CORES)
  ) mat_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_flat),
    .clr_i (clr_flat),
    .pend_o(pend_flat),
    .irq_o (irq_o)
  );
endmodule

// File: rtl/ipi_unit_chk.sv
module ipi_unit_chk
  import ipi_pkg::*;
#(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned CMD_W   = 8,
  parameter int unsigned PARAM_W = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [N_CORES-1:0]         cmd_valid_i,
  input logic [N_CORES*CMD_W-1:0]   cmd_code_i,
  input logic [N_CORES*PARAM_W-1:0] cmd_param_i,
  input logic [N_CORES-1:0]         rb_valid_o,
  input logic [N_CORES-1:0]         irq_o
);
  logic [CMD_W-1:0]   code_a [N_CORES];
  logic [PARAM_W-1:0] prm_a  [N_CORES];
  logic [N_CORES-1:0] rd_cmd, ack_any;

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    assign code_a[c]  = cmd_code_i[c*CMD_W +: CMD_W];
    assign prm_a[c]   = cmd_param_i[c*PARAM_W +: PARAM_W];
    assign rd_cmd[c]  = cmd_valid_i[c] &&
                        ((code_a[c] == CMD_W'(OP_STATUS) && prm_a[c] < PARAM_W'(N_CORES)) ||
                         code_a[c] == CMD_W'(OP_SOURCE));
    assign ack_any[c] = cmd_valid_i[c] && code_a[c] == CMD_W'(OP_ACK) &&
                        prm_a[c] < PARAM_W'(N_CORES);

    p_rb_follow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_cmd[c] |=> rb_valid_o[c]);

    p_rb_only_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rb_valid_o[c] |-> $past(rd_cmd[c]));

    p_irq_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(irq_o[c]) |-> $past(ack_any[c]));

    for (genvar t = 0; t < N_CORES; t++) begin : g_tgt
      logic raise_st, ack_ts;
      assign raise_st = cmd_valid_i[c] && code_a[c] == CMD_W'(OP_RAISE) &&
                        prm_a[c] == PARAM_W'(t);
      assign ack_ts   = cmd_valid_i[t] && code_a[t] == CMD_W'(OP_ACK) &&
                        prm_a[t] == PARAM_W'(c);

      p_raise_irq_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        raise_st |=> irq_o[t]);

      p_raise_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (raise_st && ack_ts) |=> irq_o[t]);
    end
  end
endmodule

bind ipi_unit ipi_unit_chk #(
  .N_CORES(N_CORES), .CMD_W(CMD_W), .PARAM_W(PARAM_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .cmd_code_i (cmd_code_i),
  .cmd_param_i(cmd_param_i),
  .rb_valid_o (rb_valid_o),
  .irq_o      (irq_o)
);

// File: tb/ipi_unit_tb_top.sv
module ipi_unit_tb_top;
  localparam int N  = 4;
  localparam int CW = 8;
  localparam int PW = 8;
  localparam int RW = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b1;
  logic [N-1:0]    cmd_valid = '0;
  logic [N*CW-1:0] cmd_code  = '0;
  logic [N*PW-1:0] cmd_param = '0;
  logic [N-1:0]    rb_valid_o;
  logic [N*RW-1:0] rb_data_o;
  logic [N-1:0]    irq_o;

  always #2 clk_i = ~clk_i;  // 250 MHz

  ipi_unit #(.N_CORES(N), .CMD_W(CW), .PARAM_W(PW), .RB_W(RW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid), .cmd_code_i(cmd_code), .cmd_param_i(cmd_param),
    .rb_valid_o(rb_valid_o), .rb_data_o(rb_data_o), .irq_o(irq_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit model [N][N];  // [sender][target]
  int    q_core [$];
  int    q_data [$];
  string q_tag  [$];

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put(input int c, input int code, input int prm);
    cmd_valid[c] = 1'b1;
    cmd_code[c*CW +: CW]  = CW'(code);
    cmd_param[c*PW +: PW] = PW'(prm);
  endtask

  // scoreboard driver: queue expected readbacks, advance one cycle, update model
  task automatic tick(input string tag);
    bit nxt [N][N];
    for (int c = 0; c < N; c++) begin
      if (cmd_valid[c]) begin
        int code = int'(cmd_code[c*CW +: CW]);
        int p    = int'(cmd_param[c*PW +: PW]);
        if (code == 2 && p < N) begin
          q_core.push_back(c); q_data.push_back(int'(model[c][p])); q_tag.push_back(tag);
        end else if (code == 3) begin
          int m = 0;
          for (int s = 0; s < N; s++) if (model[s][c]) m |= (1 << s);
          q_core.push_back(c); q_data.push_back(m); q_tag.push_back(tag);
        end
      end
    end
    nxt = model;
    for (int c = 0; c < N; c++) begin
      int code = int'(cmd_code[c*CW +: CW]);
      int p    = int'(cmd_param[c*PW +: PW]);
      if (cmd_valid[c] && code == 4 && p < N) nxt[p][c] = 1'b0;
    end
    for (int c = 0; c < N; c++) begin
      int code = int'(cmd_code[c*CW +: CW]);
      int p    = int'(cmd_param[c*PW +: PW]);
      if (cmd_valid[c] && code == 1 && p < N) nxt[c][p] = 1'b1;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    model = nxt;
    cmd_valid = '0;
    cmd_code  = '0;
    cmd_param = '0;
  endtask

  function automatic int model_irq();
    int v = 0;
    for (int s = 0; s < N; s++)
      for (int t = 0; t < N; t++)
        if (model[s][t]) v |= (1 << t);
    return v;
  endfunction

  task automatic check_irq(input string tag, input int exp);
    check(tag, int'(irq_o), exp);
    check({tag, " model"}, int'(irq_o), model_irq());
  endtask

  // scoreboard monitor
  always @(posedge clk_i) begin
    int d;
    string t;
    #1;
    for (int c = 0; c < N; c++) begin
      if (rb_valid_o[c]) begin
        if (q_core.size() == 0 || q_core[0] != c) begin
          n_chk++; n_fail++;
          $display("FAIL R9: unexpected readback on core %0d, actual %0h expected none",
                   c, rb_data_o[c*RW +: RW]);
        end else begin
          void'(q_core.pop_front());
          d = q_data.pop_front();
          t = q_tag.pop_front();
          check({t, " readback"}, int'(rb_data_o[c*RW +: RW]), d);
        end
      end
    end
    while (q_core.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL %s: missing readback on core %0d, actual none expected %0h",
               q_tag[0], q_core[0], q_data[0]);
      void'(q_core.pop_front()); void'(q_data.pop_front()); void'(q_tag.pop_front());
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R1 irq", int'(irq_o), 0);
    check("R1 rb_valid", int'(rb_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    put(0, 2, 2); put(2, 3, 0); tick("R1");
    check_irq("R1", 0);

    put(0, 1, 2); tick("R2");
    check_irq("R2", 4'b0100);

    put(0, 2, 2); put(1, 2, 2); tick("R3");
    put(2, 3, 0); tick("R4");

    put(1, 1, 2); put(3, 1, 2); tick("R5");
    check_irq("R5", 4'b0100);
    put(2, 3, 0); tick("R5");

    put(2, 4, 1); put(2, 4, 1); tick("R6");
    check_irq("R7 still high", 4'b0100);
    put(2, 3, 0); put(0, 2, 2); put(1, 2, 2); tick("R6");
    put(2, 4, 0); put(3, 2, 2); tick("R3 same-cycle");
    check_irq("R7", 4'b0100);
    put(2, 4, 3); tick("R7");
    check_irq("R7 fall", 0);

    put(1, 1, 3); put(3, 4, 1); tick("R8 clear");
    check_irq("R8", 4'b1000);
    put(1, 1, 3); put(3, 4, 1); tick("R8 set");
    check_irq("R8", 4'b1000);
    put(3, 4, 1); tick("R8");
    check_irq("R8", 0);

    put(0, 8'h7F, 1); put(1, 1, 9); put(2, 2, 7); put(3, 4, 9); tick("R9");
    check_irq("R9", 0);
    put(1, 3, 0); put(3, 3, 0); tick("R9");

    put(0, 1, 1); tick("R6");
    put(2, 4, 0); tick("R6 wrong core");
    check_irq("R6", 4'b0010);
    put(0, 2, 1); tick("R6");
    put(1, 4, 0); tick("R6");
    check_irq("R6", 0);

    for (int c = 0; c < N; c++) put(c, 1, (c + 1) % N);
    tick("R10");
    check_irq("R10", 4'b1111);
    for (int c = 0; c < N; c++) put(c, 3, 0);
    tick("R10");
    for (int c = 0; c < N; c++) put(c, 2, (c + 1) % N);
    tick("R10");
    for (int c = 0; c < N; c++) put(c, 4, (c + N - 1) % N);
    tick("R10");
    check_irq("R10", 0);

    repeat (2) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule